// File: doc/BRIEF.md
# Reloadable Periodic Tick Timer

A 24-bit down-counter that produces a periodic tick for an operating system scheduler. Software loads a reload value, clears the counter, and enables it. Each active tick then moves the counter one step down. From zero it reloads, so a reload value of n gives a period of n+1 ticks. A tick is either every clock cycle or each cycle in which an external reference strobe is high.

When the counter steps from 1 to 0, a sticky wrap flag is set. The flag stays set until the control register is read or the current-value register is written. If interrupts are enabled, a one-cycle interrupt pulse is raised in the same cycle as the flag.

Access uses a simple single-cycle register port. Read data is combinational in the request cycle. Writes take effect at the clock edge that ends the request.

Top module: `tick_timer`

## Requirements
- R1: After reset, all three registers read zero and `irq` is low.
- R2: The register word is chosen by `bus_addr[3:2]`: 0 is control, 1 is reload, 2 is current, and 3 reads zero. Reload and current hold 24 bits, and bits 31:24 read zero. Control reads back as run enable at bit 0, interrupt enable at bit 1, source select at bit 2 and the wrap flag at bit 16. Every other control bit reads zero.
- R3: With run enable set and source select at 1, the counter decreases by one on every clock.
- R4: On an active tick with the counter at 0, the counter takes the reload value. The sequence is n, n-1, …, 0, n, a period of n+1 ticks.
- R5: The wrap flag becomes 1 at the edge where the counter moves from 1 to 0.
- R6: A read of the control register returns the wrap flag as it stands and then clears it. A wrap in the same cycle wins over the clear.
- R7: A write of any value to the current register sets the counter and the wrap flag to zero, even while the timer runs.
- R8: With interrupt enable set, `irq` is high for exactly one cycle, in the cycle the wrap flag is set. With interrupt enable clear, `irq` stays low.
- R9: With run enable clear, the counter holds its value.
- R10: With source select at 0, the counter moves only on cycles where `ref_tick` is high.
- R11: With reload 0, the counter stays at 0 and no wrap flag or interrupt occurs.
- R12: Writes to read-only control bits, including bit 16, have no effect on what the register reads back.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_valid | input | 1 | Register access this cycle |
| bus_write | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 4 | Byte offset of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid in the request cycle |
| ref_tick | input | 1 | External reference tick enable |
| irq | output | 1 | One-cycle wrap interrupt |

## Verification
The hardest cases to reach from the ports involve the wrap edge. One is a control read landing in the very cycle the counter leaves 1. Another is a reload of 1, where wraps come every second tick. A third is the external reference pattern interacting with the wrap.

The stimulus uses a small reload so that wraps occur often. It polls the control register on every cycle around the wrap, and it toggles `ref_tick` in an uneven pattern. A behavioural model in the bench follows every cycle, so each read and every `irq` value is compared.

// File: rtl/tick_timer.sv
module tick_timer #(
  parameter int CW = 24
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        bus_valid,
  input  logic        bus_write,
  input  logic [3:0]  bus_addr,
  input  logic [31:0] bus_wdata,
  output logic [31:0] bus_rdata,
  input  logic        ref_tick,
  output logic        irq
);
  localparam logic [1:0] W_CTL = 2'd0;
  localparam logic [1:0] W_RLD = 2'd1;
  localparam logic [1:0] W_CUR = 2'd2;
  localparam logic [CW-1:0] ONE = CW'(1);

  logic [CW-1:0] cur_q, rld_q;
  logic run_q, ie_q, src_q, flag_q;

  wire [1:0] word   = bus_addr[3:2];
  wire       wr     = bus_valid && bus_write;
  wire       rd     = bus_valid && !bus_write;
  wire       wr_ctl = wr && word == W_CTL;
  wire       wr_rld = wr && word == W_RLD;
  wire       wr_cur = wr && word == W_CUR;
  wire       rd_ctl = rd && word == W_CTL;
  wire       go     = run_q && (src_q || ref_tick) && !wr_cur;
  wire       hit    = go && cur_q == ONE;
  wire       unused_bits = ^{bus_wdata[31:CW], bus_addr[1:0]};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cur_q <= '0;
      rld_q <= '0;
      run_q <= 1'b0;
      ie_q <= 1'b0;
      src_q <= 1'b0;
      flag_q <= 1'b0;
      irq <= 1'b0;
    end else begin
      if (wr_cur) cur_q <= '0;
      else if (go) cur_q <= (cur_q == '0) ? rld_q : cur_q - ONE;
      if (wr_rld) rld_q <= bus_wdata[CW-1:0];
      if (wr_ctl) {src_q, ie_q, run_q} <= bus_wdata[2:0];
      if (wr_cur) flag_q <= 1'b0;
      else if (hit) flag_q <= 1'b1;
      else if (rd_ctl) flag_q <= 1'b0;
      irq <= hit && ie_q;
    end
  end

  always_comb begin
    bus_rdata = '0;
    if (rd) begin
      case (word)
        W_CTL: begin
          bus_rdata[2:0] = {src_q, ie_q, run_q};
          bus_rdata[16]  = flag_q;
        end
        W_RLD: bus_rdata[CW-1:0] = rld_q;
        W_CUR: bus_rdata[CW-1:0] = cur_q;
        default: bus_rdata = '0;
      endcase
    end
  end

  assert_irq_single_R8: assert property (@(posedge clk) disable iff (!rst_n)
    irq |=> !irq);
  assert_irq_with_flag_R8: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> flag_q);
  assert_hold_when_off_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $past(!run_q && !wr_cur) |-> cur_q == $past(cur_q));
  assert_clear_on_write_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $past(wr_cur) |-> (cur_q == '0 && !flag_q));
  assert_wrap_reload_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $past(go && cur_q == '0) |-> cur_q == $past(rld_q));
  assert_ctl_zero_bits_R2: assert property (@(posedge clk) disable iff (!rst_n)
    rd_ctl |-> (bus_rdata[31:17] == '0 && bus_rdata[15:3] == '0));
endmodule

// File: tb/sim_tick_timer.sv
module sim_tick_timer;
  logic clk = 0, rst_n = 0;
  logic bus_valid = 0, bus_write = 0, ref_tick = 0;
  logic [3:0] bus_addr = 0;
  logic [31:0] bus_wdata = 0;
  logic [31:0] bus_rdata;
  logic irq;
  int vecs = 0, errs = 0;
  bit done = 0;
  longint m_cur = 0, m_rld = 0;
  bit m_run = 0, m_ie = 0, m_src = 0, m_flag = 0, m_irq = 0;

  tick_timer u0 (.clk(clk), .rst_n(rst_n), .bus_valid(bus_valid), .bus_write(bus_write),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .ref_tick(ref_tick), .irq(irq));

  always #2 clk = ~clk;

  function automatic longint exp_read(int a);
    case (a >> 2)
      0: return longint'(m_run) | (longint'(m_ie) << 1) | (longint'(m_src) << 2) | (longint'(m_flag) << 16);
      1: return m_rld;
      2: return m_cur;
      default: return 0;
    endcase
  endfunction

  task automatic step(bit v, bit w, int a, longint d, bit ext, string tag);
    bit wcur, wctl, wrld, rctl, tk, hit;
    longint e;
    bus_valid = v; bus_write = w; bus_addr = 4'(a); bus_wdata = 32'(d); ref_tick = ext;
    #1;
    vecs++;
    if (irq !== m_irq) begin
      errs++; $display("FAIL R8 irq actual %0b expected %0b", irq, m_irq);
    end
    if (v && !w) begin
      e = exp_read(a);
      vecs++;
      if (bus_rdata !== 32'(e)) begin
        errs++; $display("FAIL %s read @%0h actual %h expected %h", tag, a, bus_rdata, 32'(e));
      end
    end
    @(posedge clk);
    wcur = v && w && (a >> 2) == 2;
    wctl = v && w && (a >> 2) == 0;
    wrld = v && w && (a >> 2) == 1;
    rctl = v && !w && (a >> 2) == 0;
    tk = m_run && (m_src || ext) && !wcur;
    hit = 0;
    if (wcur) begin m_cur = 0; m_flag = 0; end
    else if (tk) begin
      if (m_cur == 0) m_cur = m_rld;
      else begin hit = (m_cur == 1); m_cur = m_cur - 1; end
    end
    if (hit) m_flag = 1;
    else if (rctl) m_flag = 0;
    m_irq = hit && m_ie;
    if (wrld) m_rld = d & 64'hFFFFFF;
    if (wctl) begin m_run = d[0]; m_ie = d[1]; m_src = d[2]; end
    @(negedge clk);
  endtask

  task automatic wr(int a, longint d, string tag); step(1, 1, a, d, 0, tag); endtask
  task automatic rd(int a, string tag); step(1, 0, a, 0, 0, tag); endtask

  initial begin
    #100000;
    if (!done) begin
      errs++; $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    rd(0, "R1"); rd(4, "R1"); rd(8, "R1"); rd(12, "R2");
    wr(4, 64'hFFFFFFFF, "R2"); rd(4, "R2");
    wr(0, 64'hFFFFFFF8, "R12"); rd(0, "R12");
    wr(0, 64'h10007, "R12"); rd(0, "R12"); rd(8, "R3"); rd(8, "R3"); rd(12, "R2");
    wr(0, 0, "R9"); wr(8, 123, "R7"); rd(8, "R7");
    wr(4, 4, "R4"); wr(0, 7, "R3");
    for (int i = 0; i < 14; i++) rd(i % 3 == 2 ? 0 : 8, i < 4 ? "R3" : (i % 3 == 2 ? "R6" : "R4"));
    for (int i = 0; i < 12; i++) rd(0, "R5");
    wr(0, 3, "R10");
    for (int i = 0; i < 30; i++) step(1, 0, (i % 4 == 3) ? 0 : 8, 0, (i % 3) != 1, "R10");
    wr(0, 6, "R9");
    for (int i = 0; i < 6; i++) rd(8, "R9");
    wr(0, 5, "R7");
    for (int i = 0; i < 3; i++) rd(8, "R7");
    wr(8, 0, "R7"); rd(0, "R7"); rd(8, "R7");
    for (int i = 0; i < 8; i++) rd(i % 2 ? 0 : 8, "R4");
    wr(8, 5, "R7"); rd(0, "R7");
    wr(4, 0, "R11"); wr(8, 0, "R11"); wr(0, 7, "R11");
    for (int i = 0; i < 10; i++) rd(i % 2 ? 0 : 8, "R11");
    wr(4, 1, "R8"); wr(8, 0, "R8");
    for (int i = 0; i < 12; i++) rd(i % 3 == 0 ? 0 : 8, "R8");
    wr(0, 5, "R8");
    for (int i = 0; i < 8; i++) rd(0, "R8");
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
    $finish;
  end
endmodule